// File: doc/BRIEF.md
# TLB Invalidation Scan Engine

This block carries out the maintenance commands that drop translations from a two-part TLB. One part is set-associative, with `SA_WAYS` ways of `SA_SETS` sets. The other part is fully associative, with `FA_N` entries. Entries are numbered `way*SA_SETS + set` for the set-associative part. The fully associative entries follow them, starting at `SA_WAYS*SA_SETS`. The attribute storage stays outside the engine. The engine names one entry per cycle on `ent_idx` and reads back that entry's valid bit, global bit, ASID, VPPN and page size in the same cycle. For each entry that must be dropped, it pulses `inv_we` with `inv_idx`, and the storage clears that entry's valid bit on the clock edge.

A command is accepted by a one-cycle `start` while the engine is idle. The command code, the index, the ASID, the virtual page number (address bits 47:13) and the global selector are captured at that moment. The engine then walks its scope, one entry per cycle. It finishes with a single cycle in which `done` and `flush_req` are high together. `flush_req` asks the downstream translation cache to drop everything it holds. Page sizes are given as log2 of the byte size. The set-associative part uses the shared size `shared_ps`. Each fully associative entry uses its own size.

The controller has three states:
- **IDLE**: waits for a command. Transitions: *accept* (to SCAN when the scope holds entries) and *empty-scope* (straight to FINISH when it holds none).
- **SCAN**: examines one entry per cycle. Transition: *last-entry* (to FINISH after the final entry of the scope).
- **FINISH**: raises `done` and `flush_req`. Transition: *retire* (back to IDLE).

Top module: `tlbinv_scan_engine`

## Requirements
- R1: While reset is held, and in the cycle after its release, `busy`, `done`, `flush_req` and `inv_we` are all low.
- R2: Command codes 0 (clear) and 1 (flush) with `idx` below `SA_WAYS*SA_SETS` examine only the `SA_WAYS` entries `w*SA_SETS + idx%SA_SETS`, in ascending way order `w`.
- R3: Codes 0 and 1 with `idx` inside the fully associative range examine every fully associative entry, in ascending order. With `idx` at or beyond the total entry count, they examine no entry.
- R4: Clear (code 0) drops an entry only if the entry is non-global and its ASID equals `op_asid`. Flush (code 1) drops every entry in its scope.
- R5: Codes 2, 3 and 4 examine all entries in ascending order. Code 2 drops every entry. Code 3 drops an entry when its global bit equals `g_sel`. Code 4 drops an entry when it is non-global and its ASID equals `op_asid`.
- R6: A page match holds when `(op_vpn ^ ent_vppn) >> max(ps-12, 0)` is zero. Here `ps` is `shared_ps` for set-associative entries and the entry's own `ent_ps` for fully associative ones.
- R7: Code 5 drops a page-matching entry that is non-global and has an ASID equal to `op_asid`. Code 6 drops a page-matching entry that is global or has an ASID equal to `op_asid`. Code 7 examines no entry.
- R8: No write is issued to an entry whose valid bit is already 0.
- R9: Entries are examined one per cycle. The k-th entry of the scope is on `ent_idx` in the k-th cycle after the `start` edge. `busy` is high from the cycle after `start` up to and including the `done` cycle. For a scope of N entries, `done` comes N+1 cycles after `start`.
- R10: Every command, including code 7 and an empty scope, ends with exactly one cycle in which `done` and `flush_req` are both high. The engine is idle in the following cycle.
- R11: A `start` that arrives while `busy` is high is ignored. The running command completes with the operands it captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command request, taken while idle |
| cmd | input | 3 | Command code (0..7) |
| idx | input | IDX_W | Entry index that selects the clear/flush scope |
| op_asid | input | ASID_W | ASID operand |
| op_vpn | input | VPPN_W | Virtual address bits 47:13 |
| g_sel | input | 1 | Global value for code 3 |
| shared_ps | input | PS_W | Page size of the set-associative part |
| ent_idx | output | ENT_W | Entry being examined |
| ent_e | input | 1 | Valid bit of that entry |
| ent_g | input | 1 | Global bit of that entry |
| ent_asid | input | ASID_W | ASID of that entry |
| ent_vppn | input | VPPN_W | VPPN of that entry |
| ent_ps | input | PS_W | Page size stored with that entry |
| inv_we | output | 1 | Clear the valid bit of `inv_idx` |
| inv_idx | output | ENT_W | Entry to clear |
| busy | output | 1 | A command is in progress |
| done | output | 1 | Command complete, one cycle |
| flush_req | output | 1 | Downstream cache flush request, one cycle |

## Verification
The k-th entry of a scope is on `ent_idx` in cycle k after the `start` edge, so its write, if any, appears in that same cycle. `done` and `flush_req` appear in cycle N+1, and the engine is idle in cycle N+2. The bench drives `start` at a falling edge and counts falling edges from there. For each cycle it checks `inv_idx` against the entry number predicted for that cycle, and it confirms that the pulse arrives exactly in cycle N+1. The valid map that results is then compared entry by entry against a model built from the requirements.

// File: rtl/tlbinv_pkg.sv
package tlbinv_pkg;

    typedef enum logic [2:0] {
        CMD_CLEAR     = 3'd0,
        CMD_FLUSH     = 3'd1,
        CMD_INV_ALL   = 3'd2,
        CMD_INV_G     = 3'd3,
        CMD_INV_ASID  = 3'd4,
        CMD_PAGE_PRIV = 3'd5,
        CMD_PAGE_ANY  = 3'd6,
        CMD_NOP       = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_FINISH = 2'd2
    } state_e;

endpackage

// File: rtl/tlbinv_plan.sv
module tlbinv_plan
    import tlbinv_pkg::*;
#(
    parameter int SA_WAYS = 8,
    parameter int SA_SETS = 256,
    parameter int FA_N    = 64,
    parameter int IDX_W   = 12,
    parameter int ENT_W   = 12,
    parameter int CNT_W   = 12
) (
    input  cmd_e             cmd,
    input  logic [IDX_W-1:0] idx,
    output logic [ENT_W-1:0] first,
    output logic [ENT_W-1:0] stride,
    output logic [CNT_W-1:0] count
);
    localparam int SA_N  = SA_WAYS * SA_SETS;
    localparam int TOTAL = SA_N + FA_N;
    localparam int SET_W = (SA_SETS > 1) ? $clog2(SA_SETS) : 1;

    logic [ENT_W-1:0] set_no;

    // Set extraction: a bit slice for power-of-two set counts, a modulo otherwise.
    generate
        if ((SA_SETS & (SA_SETS - 1)) == 0) begin : g_pow2_sets
            assign set_no = ENT_W'(idx[SET_W-1:0]);
        end else begin : g_mod_sets
            assign set_no = ENT_W'(idx % IDX_W'(SA_SETS));
        end
    endgenerate

    always_comb begin
        first  = '0;
        stride = ENT_W'(1);
        count  = '0;
        unique case (cmd)
            CMD_CLEAR, CMD_FLUSH: begin
                if (32'(idx) < SA_N) begin
                    first  = set_no;
                    stride = ENT_W'(SA_SETS);
                    count  = CNT_W'(SA_WAYS);
                end else if (32'(idx) < TOTAL) begin
                    first  = ENT_W'(SA_N);
                    count  = CNT_W'(FA_N);
                end
            end
            CMD_INV_ALL, CMD_INV_G, CMD_INV_ASID, CMD_PAGE_PRIV, CMD_PAGE_ANY: begin
                count = CNT_W'(TOTAL);
            end
            CMD_NOP: begin
                count = '0;
            end
        endcase
    end
endmodule

// File: rtl/tlbinv_match.sv
module tlbinv_match
    import tlbinv_pkg::*;
#(
    parameter int ASID_W   = 10,
    parameter int VPPN_W   = 35,
    parameter int PS_W     = 6,
    parameter int PG_SHIFT = 12
) (
    input  cmd_e              cmd,
    input  logic [ASID_W-1:0] op_asid,
    input  logic [VPPN_W-1:0] op_vpn,
    input  logic              g_sel,
    input  logic              ent_g,
    input  logic [ASID_W-1:0] ent_asid,
    input  logic [VPPN_W-1:0] ent_vppn,
    input  logic [PS_W-1:0]   eff_ps,
    output logic              match
);
    logic [PS_W-1:0]   sh;
    logic [VPPN_W-1:0] diff;
    logic              page_ok;
    logic              asid_eq;

    // Compare at double-page granularity: drop the bits below ps+1.
    always_comb begin
        sh      = (eff_ps > PS_W'(PG_SHIFT)) ? (eff_ps - PS_W'(PG_SHIFT)) : '0;
        diff    = op_vpn ^ ent_vppn;
        page_ok = ((diff >> sh) == '0);
        asid_eq = (ent_asid == op_asid);
    end

    always_comb begin
        match = 1'b0;
        unique case (cmd)
            CMD_CLEAR:     match = !ent_g && asid_eq;
            CMD_FLUSH:     match = 1'b1;
            CMD_INV_ALL:   match = 1'b1;
            CMD_INV_G:     match = (ent_g == g_sel);
            CMD_INV_ASID:  match = !ent_g && asid_eq;
            CMD_PAGE_PRIV: match = !ent_g && asid_eq && page_ok;
            CMD_PAGE_ANY:  match = (ent_g || asid_eq) && page_ok;
            CMD_NOP:       match = 1'b0;
        endcase
    end
endmodule

// File: rtl/tlbinv_fsm.sv
module tlbinv_fsm
    import tlbinv_pkg::*;
#(
    parameter int ENT_W  = 12,
    parameter int CNT_W  = 12,
    parameter int ASID_W = 10,
    parameter int VPPN_W = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ENT_W-1:0]  plan_first,
    input  logic [ENT_W-1:0]  plan_stride,
    input  logic [CNT_W-1:0]  plan_count,
    input  cmd_e              cmd_in,
    input  logic [ASID_W-1:0] asid_in,
    input  logic [VPPN_W-1:0] vpn_in,
    input  logic              gsel_in,
    output logic [ENT_W-1:0]  cursor,
    output cmd_e              cmd_q,
    output logic [ASID_W-1:0] asid_q,
    output logic [VPPN_W-1:0] vpn_q,
    output logic              gsel_q,
    output logic              busy,
    output logic              scanning,
    output logic              done
);
    state_e           state_q, state_d;
    logic [ENT_W-1:0] stride_q;
    logic [CNT_W-1:0] left_q;
    logic             accept;

    assign accept = (state_q == ST_IDLE) && start;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions: accept, empty-scope, last-entry, retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = (plan_count == '0) ? ST_FINISH : ST_SCAN;
            end
            ST_SCAN: begin
                if (left_q == CNT_W'(1)) state_d = ST_FINISH;
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Cursor, remaining count and captured operands
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cursor   <= '0;
            stride_q <= '0;
            left_q   <= '0;
            cmd_q    <= CMD_NOP;
            asid_q   <= '0;
            vpn_q    <= '0;
            gsel_q   <= 1'b0;
        end else if (accept) begin
            cursor   <= plan_first;
            stride_q <= plan_stride;
            left_q   <= plan_count;
            cmd_q    <= cmd_in;
            asid_q   <= asid_in;
            vpn_q    <= vpn_in;
            gsel_q   <= gsel_in;
        end else if (state_q == ST_SCAN) begin
            cursor <= cursor + stride_q;
            left_q <= left_q - CNT_W'(1);
        end
    end

    // Outputs
    always_comb begin
        busy     = (state_q != ST_IDLE);
        scanning = (state_q == ST_SCAN);
        done     = (state_q == ST_FINISH);
    end

    a_r9_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
    a_r11_operands_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(cmd_q) && $stable(vpn_q) && $stable(asid_q)));
endmodule

// File: rtl/tlbinv_scan_engine.sv
module tlbinv_scan_engine
    import tlbinv_pkg::*;
#(
    parameter int SA_WAYS  = 8,
    parameter int SA_SETS  = 256,
    parameter int FA_N     = 64,
    parameter int ASID_W   = 10,
    parameter int VA_W     = 48,
    parameter int PG_SHIFT = 12,
    parameter int PS_W     = 6,
    parameter int IDX_W    = 12,
    localparam int SA_N    = SA_WAYS * SA_SETS,
    localparam int TOTAL   = SA_N + FA_N,
    localparam int ENT_W   = $clog2(TOTAL),
    localparam int CNT_W   = $clog2(TOTAL + 1),
    localparam int VPPN_W  = VA_W - PG_SHIFT - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [2:0]        cmd,
    input  logic [IDX_W-1:0]  idx,
    input  logic [ASID_W-1:0] op_asid,
    input  logic [VPPN_W-1:0] op_vpn,
    input  logic              g_sel,
    input  logic [PS_W-1:0]   shared_ps,
    output logic [ENT_W-1:0]  ent_idx,
    input  logic              ent_e,
    input  logic              ent_g,
    input  logic [ASID_W-1:0] ent_asid,
    input  logic [VPPN_W-1:0] ent_vppn,
    input  logic [PS_W-1:0]   ent_ps,
    output logic              inv_we,
    output logic [ENT_W-1:0]  inv_idx,
    output logic              busy,
    output logic              done,
    output logic              flush_req
);
    cmd_e              cmd_in;
    logic [ENT_W-1:0]  plan_first, plan_stride, cursor;
    logic [CNT_W-1:0]  plan_count;
    cmd_e              cmd_q;
    logic [ASID_W-1:0] asid_q;
    logic [VPPN_W-1:0] vpn_q;
    logic              gsel_q;
    logic              scanning;
    logic [PS_W-1:0]   eff_ps;
    logic              cond;

    assign cmd_in = cmd_e'(cmd);

    tlbinv_plan #(
        .SA_WAYS(SA_WAYS), .SA_SETS(SA_SETS), .FA_N(FA_N),
        .IDX_W(IDX_W), .ENT_W(ENT_W), .CNT_W(CNT_W)
    ) i_plan (
        .cmd(cmd_in), .idx(idx),
        .first(plan_first), .stride(plan_stride), .count(plan_count)
    );

    tlbinv_fsm #(
        .ENT_W(ENT_W), .CNT_W(CNT_W), .ASID_W(ASID_W), .VPPN_W(VPPN_W)
    ) i_fsm (
        .clk(clk), .rst_n(rst_n), .start(start),
        .plan_first(plan_first), .plan_stride(plan_stride), .plan_count(plan_count),
        .cmd_in(cmd_in), .asid_in(op_asid), .vpn_in(op_vpn), .gsel_in(g_sel),
        .cursor(cursor), .cmd_q(cmd_q), .asid_q(asid_q), .vpn_q(vpn_q),
        .gsel_q(gsel_q), .busy(busy), .scanning(scanning), .done(done)
    );

    // Set-associative entries share one page size; the rest carry their own.
    assign eff_ps = (32'(cursor) >= SA_N) ? ent_ps : shared_ps;

    tlbinv_match #(
        .ASID_W(ASID_W), .VPPN_W(VPPN_W), .PS_W(PS_W), .PG_SHIFT(PG_SHIFT)
    ) i_match (
        .cmd(cmd_q), .op_asid(asid_q), .op_vpn(vpn_q), .g_sel(gsel_q),
        .ent_g(ent_g), .ent_asid(ent_asid), .ent_vppn(ent_vppn),
        .eff_ps(eff_ps), .match(cond)
    );

    assign ent_idx   = cursor;
    assign inv_idx   = cursor;
    assign inv_we    = scanning && ent_e && cond;
    assign flush_req = done;

    a_r8_no_write_to_empty: assert property (@(posedge clk) disable iff (!rst_n)
        inv_we |-> ent_e);
    a_r3_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        inv_we |-> (32'(inv_idx) < TOTAL));
    a_r9_write_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        inv_we |-> (busy && !done));
    a_r3_empty_scope_finishes: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && plan_count == '0) |=> done);
endmodule

// File: tb/test_tlbinv_scan_engine.sv
module test_tlbinv_scan_engine;
    localparam int WAYS = 8, SETS = 256, FAN = 64;
    localparam int SAN = WAYS * SETS, TOT = SAN + FAN;
    localparam int EW = 12, VW = 35;

    typedef struct packed {
        logic [2:0]  c;
        logic [11:0] ix;
        logic [9:0]  as;
        logic [34:0] vp;
        logic        gs;
        logic [5:0]  sps;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 12'd5,    10'd1, 35'd0, 1'b0, 6'd12},   // clear, line
        '{3'd0, 12'd2050, 10'd2, 35'd0, 1'b0, 6'd12},   // clear, FA part
        '{3'd1, 12'd300,  10'd0, 35'd0, 1'b0, 6'd12},   // flush, line 44
        '{3'd1, 12'd2100, 10'd0, 35'd0, 1'b0, 6'd12},   // flush, FA part
        '{3'd1, 12'd3000, 10'd0, 35'd0, 1'b0, 6'd12},   // flush, out of range
        '{3'd0, 12'd2112, 10'd1, 35'd0, 1'b0, 6'd12},   // clear, first index past end
        '{3'd2, 12'd0,    10'd0, 35'd0, 1'b0, 6'd12},   // all
        '{3'd3, 12'd0,    10'd0, 35'd0, 1'b1, 6'd12},   // by G=1
        '{3'd3, 12'd0,    10'd0, 35'd0, 1'b0, 6'd12},   // by G=0
        '{3'd4, 12'd0,    10'd3, 35'd0, 1'b0, 6'd12},   // by ASID
        '{3'd5, 12'd0,    10'd1, 35'd5, 1'b0, 6'd12},   // page, private
        '{3'd6, 12'd0,    10'd2, 35'd7, 1'b0, 6'd14},   // page, global or ASID
        '{3'd5, 12'd0,    10'd0, 35'h4_0000_0000, 1'b0, 6'd12}, // page, no hit
        '{3'd7, 12'd5,    10'd1, 35'd0, 1'b0, 6'd12}    // reserved
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] cmd = '0;
    logic [11:0] idx = '0;
    logic [9:0] op_asid = '0;
    logic [34:0] op_vpn = '0;
    logic g_sel = 1'b0;
    logic [5:0] shared_ps = 6'd12;
    logic [EW-1:0] ent_idx, inv_idx;
    logic ent_e, ent_g, inv_we, busy, done, flush_req;
    logic [9:0] ent_asid;
    logic [34:0] ent_vppn;
    logic [5:0] ent_ps;

    logic        m_e [TOT];
    logic        m_g [TOT];
    logic [9:0]  m_a [TOT];
    logic [34:0] m_v [TOT];
    logic [5:0]  m_p [TOT];
    logic        x_e [TOT];

    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    tlbinv_scan_engine i_tlbinv_scan_engine (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd(cmd), .idx(idx),
        .op_asid(op_asid), .op_vpn(op_vpn), .g_sel(g_sel), .shared_ps(shared_ps),
        .ent_idx(ent_idx), .ent_e(ent_e), .ent_g(ent_g), .ent_asid(ent_asid),
        .ent_vppn(ent_vppn), .ent_ps(ent_ps), .inv_we(inv_we), .inv_idx(inv_idx),
        .busy(busy), .done(done), .flush_req(flush_req)
    );

    assign ent_e    = m_e[ent_idx];
    assign ent_g    = m_g[ent_idx];
    assign ent_asid = m_a[ent_idx];
    assign ent_vppn = m_v[ent_idx];
    assign ent_ps   = m_p[ent_idx];

    always @(posedge clk) if (inv_we) m_e[inv_idx] <= 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic populate();
        for (int i = 0; i < TOT; i++) begin
            m_e[i] = (i % 3) != 0;
            m_g[i] = (i % 5) == 0;
            m_a[i] = 10'(i % 4);
            m_v[i] = 35'(i % 16);
            m_p[i] = (i < SAN) ? 6'd40 : 6'(12 + 2 * (i % 4));
        end
    endtask

    // Scope per R2, R3, R5, R7
    function automatic void plan(input vec_t v, output int f, output int s, output int n);
        f = 0; s = 1; n = 0;
        if (v.c <= 3'd1) begin
            if (int'(v.ix) < SAN) begin f = int'(v.ix) % SETS; s = SETS; n = WAYS; end
            else if (int'(v.ix) < TOT) begin f = SAN; n = FAN; end
        end else if (v.c != 3'd7) n = TOT;
    endfunction

    // Drop condition per R4, R5, R6, R7
    function automatic bit drops(input vec_t v, input int i);
        int ps, sh;
        bit pm, ae;
        ps = (i < SAN) ? int'(v.sps) : 12 + 2 * (i % 4);
        sh = (ps > 12) ? ps - 12 : 0;
        pm = ((v.vp ^ 35'(i % 16)) >> sh) == 0;
        ae = (10'(i % 4) == v.as);
        case (v.c)
            3'd0: return !((i % 5) == 0) && ae;
            3'd1, 3'd2: return 1'b1;
            3'd3: return ((i % 5) == 0) == v.gs;
            3'd4: return !((i % 5) == 0) && ae;
            3'd5: return !((i % 5) == 0) && ae && pm;
            3'd6: return (((i % 5) == 0) || ae) && pm;
            default: return 1'b0;
        endcase
    endfunction

    task automatic run(input vec_t v, input bit inject, input string tag);
        int f, s, n, lat, wr, xw, oerr, ferr, miss;
        plan(v, f, s, n);
        populate();
        xw = 0;
        for (int i = 0; i < TOT; i++) begin
            bit inscope;
            inscope = (n == TOT) || (n == FAN && i >= SAN) ||
                      (n == WAYS && i < SAN && (i % SETS) == f);
            x_e[i] = m_e[i] && !(inscope && drops(v, i));
            if (m_e[i] && !x_e[i]) xw++;
        end
        @(negedge clk);
        cmd = v.c; idx = v.ix; op_asid = v.as; op_vpn = v.vp; g_sel = v.gs;
        shared_ps = v.sps; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1; wr = 0; oerr = 0; ferr = 0;
        forever begin
            if (inject && lat == 5) begin
                start = 1'b1; cmd = 3'd0; idx = 12'd2100; op_asid = 10'd3; op_vpn = 35'd9;
            end
            if (inject && lat == 6) start = 1'b0;
            if (inv_we) begin
                wr++;
                if (int'(inv_idx) != f + (lat - 1) * s) oerr++;
            end
            if (flush_req != done) ferr++;
            if (done || lat > 3000) break;
            @(negedge clk);
            lat++;
        end
        check(lat == n + 1, {tag, " R9 done cycle"}, lat, n + 1);
        check(oerr == 0, {tag, " R2/R3 scan order"}, oerr, 0);
        check(wr == xw, {tag, " R8 write count"}, wr, xw);
        check(ferr == 0 && flush_req, {tag, " R10 flush with done"}, ferr, 0);
        miss = 0;
        for (int i = 0; i < TOT; i++) if (m_e[i] !== x_e[i]) miss++;
        check(miss == 0, {tag, " R4-R7 valid map"}, miss, 0);
        @(negedge clk);
        check(!busy && !done && !flush_req, {tag, " R10 idle after done"}, busy, 0);
    endtask

    initial begin
        populate();
        repeat (3) @(negedge clk);
        check(!busy && !done && !flush_req && !inv_we, "R1 in reset", busy, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !done && !flush_req && !inv_we, "R1 after release", done, 0);
        for (int k = 0; k < NV; k++) run(VEC[k], 1'b0, $sformatf("vec%0d", k));
        // R11: a second start during a full-table scan is ignored
        run(VEC[6], 1'b1, "R11 start while busy");
        // R6: set-associative entries ignore their own stored page size
        run('{3'd6, 12'd0, 10'd1, 35'd3, 1'b0, 6'd16}, 1'b0, "R6 shared size");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule